// File: doc/BRIEF.md
# Iterative Decoder Early-Stop Checker

This block watches one codeword per decoding iteration and decides whether the iterative decoder may stop. For every position of the codeword it receives three soft values as a serial stream. The first is the soft estimate of the outer-code input bit. The other two are the extrinsic soft outputs for the two outer-code coded bits. Frame markers bound the codeword. Each soft value is turned into a hard bit. The decided input bits are run through the outer encoder again. That encoder is a tail-biting code whose two outputs are both generated by 1+D. Each re-encoded bit is then compared with the matching extrinsic hard bit.

At the end of each frame the checker reports a verdict. It raises converged when every position agreed. It raises stop when the codeword converged or when the iteration limit has been reached. It also reports how many iterations have been seen for the current codeword. The decoder marks the first iteration of a new codeword with a flag at frame start, and that flag restarts the count.

Top module: `ets_early_stop`

## Requirements
- R1: Each soft value is a two's complement number of SOFT_W bits. A strictly positive value decides to bit 1. Zero or a negative value decides to bit 0.
- R2: At position i the expected coded bit is u(i) XOR u(i-1), where u is the decided input bit. Both extrinsic hard bits at that position must equal it.
- R3: Tail-biting: for position 0, u(i-1) is the decided input bit of the last position of the same frame.
- R4: A mismatch at any position of a frame clears converged for that frame. The mismatch memory is cleared at the next frame start, so a following frame is judged on its own.
- R5: done_o is high for exactly the one cycle after the beat that carries in_eof. Beats with in_valid low are ignored, including their markers and data. done_o stays low while a frame is still in progress.
- R6: A frame whose start beat carries in_new_cw reports iter_count_o = 1. Every other frame reports the previous count plus one.
- R7: stop_o = converged_o OR (iter_count_o == MAX_ITER), with MAX_ITER = 32 by default. The count saturates at MAX_ITER.
- R8: After reset, done_o, stop_o and converged_o are 0 and iter_count_o is 0. The verdict outputs hold their value between frame ends.
- R9: A one-beat frame (in_sof and in_eof on the same beat) has an expected coded bit of 0 on both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Beat qualifier |
| in_sof | input | 1 | First position of the frame |
| in_eof | input | 1 | Last position of the frame |
| in_new_cw | input | 1 | With in_sof: first iteration of a new codeword |
| in_info_llr | input | SOFT_W | Soft value of the outer-code input bit |
| in_ext0_llr | input | SOFT_W | Extrinsic soft value, first coded output |
| in_ext1_llr | input | SOFT_W | Extrinsic soft value, second coded output |
| done_o | output | 1 | One-cycle verdict strobe |
| stop_o | output | 1 | Decoder may stop iterating |
| converged_o | output | 1 | Every position of the last frame agreed |
| iter_count_o | output | CNT_W | Iterations seen for the current codeword |

## Verification
Directed frames target the wrap-around position. The bench sends a codeword whose first and last decided bits differ. A checker that started its encoder from zero would reject the correct extrinsic bits and accept the wrong ones. Soft values of exactly zero are placed where the deciding rule changes the verdict. The bench also covers a mismatch followed by a clean frame, which shows whether the fail memory is cleared at frame start. Other cases are idle beats carrying misleading markers inside a frame, one-beat frames, and 33 iterations of one codeword, which show the stop at the limit and the saturation of the count.

// File: rtl/ets_pkg.sv
// Shared types for the early-stop checker.
package ets_pkg;
    // Lane order of the soft-value inputs: input bit, coded output 0, coded output 1.
    localparam int LANES = 3;

    typedef struct packed {
        logic info;
        logic ext0;
        logic ext1;
    } ets_bits_t;
endpackage

// File: rtl/ets_slicer.sv
// Hard-decision slicer. Turns each lane of soft values into one bit.
// Assumes two's complement soft values. Strictly positive gives 1, zero or negative gives 0.
module ets_slicer
    import ets_pkg::*;
#(
    parameter int SOFT_W = 6
) (
    input  logic [LANES*SOFT_W-1:0] soft_i,
    output ets_bits_t               bits_o
);
    logic [LANES-1:0] hard;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SOFT_W-1:0] lane;
        assign lane = soft_i[g*SOFT_W +: SOFT_W];
        // Decide: sign clear and magnitude nonzero.
        assign hard[g] = !lane[SOFT_W-1] && (|lane[SOFT_W-2:0]);

        // R1: a zero soft value never decides to 1
        always_comb begin
            if (lane == '0) a_r1_zero_decides_zero: assert (!hard[g]);
        end
    end

    assign bits_o = '{info: hard[0], ext0: hard[1], ext1: hard[2]};
endmodule

// File: rtl/ets_reencode_cmp.sv
// Re-encodes the decided input bits with the tail-biting 1+D outer code.
// It compares each coded bit against both extrinsic hard bits.
// Position 0 is held back and checked on the last beat, when the wrap-around bit is known.
// Assumes frames are well formed: one sof beat, then data beats, then one eof beat.
module ets_reencode_cmp
    import ets_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      valid_i,
    input  logic      sof_i,
    input  logic      eof_i,
    input  ets_bits_t bits_i,
    output logic      frame_end_o,
    output logic      frame_fail_o
);
    logic prev_bit_q;
    logic first_info_q, first_e0_q, first_e1_q;
    logic fail_q;

    logic code_cur, mis_cur;
    logic f_info, f_e0, f_e1, code_first, mis_first;
    logic fail_base;

    // Compare the current position (not position 0) and the deferred position 0.
    always_comb begin
        code_cur    = bits_i.info ^ prev_bit_q;
        mis_cur     = valid_i && !sof_i && ((bits_i.ext0 ^ code_cur) || (bits_i.ext1 ^ code_cur));
        f_info      = sof_i ? bits_i.info : first_info_q;
        f_e0        = sof_i ? bits_i.ext0 : first_e0_q;
        f_e1        = sof_i ? bits_i.ext1 : first_e1_q;
        code_first  = f_info ^ bits_i.info;
        mis_first   = valid_i && eof_i && ((f_e0 ^ code_first) || (f_e1 ^ code_first));
        fail_base   = (valid_i && sof_i) ? 1'b0 : fail_q;
        frame_end_o = valid_i && eof_i;
        frame_fail_o = fail_base || mis_cur || mis_first;
    end

    // Track the previous bit, the first position, and the sticky fail flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_bit_q   <= 1'b0;
            first_info_q <= 1'b0;
            first_e0_q   <= 1'b0;
            first_e1_q   <= 1'b0;
            fail_q       <= 1'b0;
        end else if (valid_i) begin
            prev_bit_q <= bits_i.info;
            fail_q     <= fail_base || mis_cur;
            if (sof_i) begin
                first_info_q <= bits_i.info;
                first_e0_q   <= bits_i.ext0;
                first_e1_q   <= bits_i.ext1;
            end
        end
    end

    // R4: the fail flag is only cleared by a frame start
    a_r4_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && !(valid_i && sof_i)) |=> fail_q);
endmodule

// File: rtl/ets_iter_ctr.sv
// Counts iterations per codeword and registers the verdict at each frame end.
// Assumes in_new_cw is meaningful only on a frame-start beat.
module ets_iter_ctr #(
    parameter int MAX_ITER = 32,
    localparam int CNT_W = $clog2(MAX_ITER + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             sof_i,
    input  logic             new_cw_i,
    input  logic             frame_end_i,
    input  logic             frame_fail_i,
    output logic             done_o,
    output logic             converged_o,
    output logic             stop_o,
    output logic [CNT_W-1:0] iter_count_o
);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_ITER);

    logic             new_pend_q;
    logic             new_eff;
    logic [CNT_W-1:0] cnt_next;

    // Next count: restart on a new codeword, otherwise increment with saturation.
    always_comb begin
        new_eff = (valid_i && sof_i) ? new_cw_i : new_pend_q;
        if (new_eff)                 cnt_next = CNT_W'(1);
        else if (iter_count_o == MAX_C) cnt_next = MAX_C;
        else                         cnt_next = iter_count_o + CNT_W'(1);
    end

    // Hold the new-codeword flag from the frame start to the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)                new_pend_q <= 1'b0;
        else if (valid_i && sof_i) new_pend_q <= new_cw_i;
    end

    // Register the verdict and the count at each frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o       <= 1'b0;
            converged_o  <= 1'b0;
            stop_o       <= 1'b0;
            iter_count_o <= '0;
        end else begin
            done_o <= frame_end_i;
            if (frame_end_i) begin
                converged_o  <= !frame_fail_i;
                stop_o       <= !frame_fail_i || (cnt_next == MAX_C);
                iter_count_o <= cnt_next;
            end
        end
    end

    // R5: done_o only follows an accepted end-of-frame beat
    a_r5_done_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(valid_i && sof_i || valid_i) && $past(frame_end_i));
    // R7: a converged frame always stops
    a_r7_conv_stops: assert property (@(posedge clk) disable iff (!rst_n)
        converged_o |-> stop_o);
    // R7: the count never passes the limit
    a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        iter_count_o <= MAX_C);
    // R6: a reported verdict always carries a nonzero count
    a_r6_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> iter_count_o != '0);
    // R8: reset clears the strobe and the count
    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!done_o && iter_count_o == '0));
endmodule

// File: rtl/ets_early_stop.sv
// Early-stop checker top. Slices the serial soft values, re-encodes the decided outer-code input bits
// and compares them per position, then reports a per-iteration verdict.
// Assumes one beat per codeword position and frames that do not overlap.
module ets_early_stop
    import ets_pkg::*;
#(
    parameter int SOFT_W   = 6,
    parameter int MAX_ITER = 32,
    localparam int CNT_W   = $clog2(MAX_ITER + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_new_cw,
    input  logic [SOFT_W-1:0] in_info_llr,
    input  logic [SOFT_W-1:0] in_ext0_llr,
    input  logic [SOFT_W-1:0] in_ext1_llr,
    output logic              done_o,
    output logic              stop_o,
    output logic              converged_o,
    output logic [CNT_W-1:0]  iter_count_o
);
    ets_bits_t bits;
    logic      frame_end, frame_fail;

    ets_slicer #(.SOFT_W(SOFT_W)) u_slicer (
        .soft_i ({in_ext1_llr, in_ext0_llr, in_info_llr}),
        .bits_o (bits)
    );

    ets_reencode_cmp u_cmp (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_i      (in_valid),
        .sof_i        (in_sof),
        .eof_i        (in_eof),
        .bits_i       (bits),
        .frame_end_o  (frame_end),
        .frame_fail_o (frame_fail)
    );

    ets_iter_ctr #(.MAX_ITER(MAX_ITER)) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_i      (in_valid),
        .sof_i        (in_sof),
        .new_cw_i     (in_new_cw),
        .frame_end_i  (frame_end),
        .frame_fail_i (frame_fail),
        .done_o       (done_o),
        .converged_o  (converged_o),
        .stop_o       (stop_o),
        .iter_count_o (iter_count_o)
    );
endmodule

// File: tb/ets_early_stop_test.sv
module ets_early_stop_test;
    localparam int SW = 6;
    localparam int MX = 32;
    localparam int CW = $clog2(MX + 1);

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_sof = 0, in_eof = 0, in_new_cw = 0;
    logic [SW-1:0] in_info_llr = '0, in_ext0_llr = '0, in_ext1_llr = '0;
    logic done_o, stop_o, converged_o;
    logic [CW-1:0] iter_count_o;

    int n_chk = 0, n_fail = 0, exp_count = 0;
    int fi[16], f0[16], f1[16];

    ets_early_stop #(.SOFT_W(SW), .MAX_ITER(MX)) uut (.*);

    always #4 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Clean frame: coded bit c(i) = u(i) ^ u(i-1 mod n), sign +5 for 1, -5 for 0.
    task automatic make_clean(int n, logic [15:0] u);
        for (int i = 0; i < n; i++) begin
            automatic logic c = u[i] ^ u[(i + n - 1) % n];
            fi[i] = u[i] ? 5 : -5;
            f0[i] = c ? 5 : -5;
            f1[i] = c ? 5 : -5;
        end
    endtask

    task automatic send_frame(int n, bit nc, bit gaps, bit exp_conv, string req);
        for (int i = 0; i < n; i++) begin
            if (gaps && i > 0) begin
                @(negedge clk);
                chk("R5", int'(done_o), 0);
                in_valid = 0; in_sof = 1; in_eof = 1; in_new_cw = 1;
                in_info_llr = SW'(31); in_ext0_llr = SW'(-31); in_ext1_llr = SW'(-31);
            end
            @(negedge clk);
            if (i > 0) chk("R5", int'(done_o), 0);
            in_valid = 1; in_sof = (i == 0); in_eof = (i == n - 1);
            in_new_cw = nc && (i == 0);
            in_info_llr = SW'(fi[i]); in_ext0_llr = SW'(f0[i]); in_ext1_llr = SW'(f1[i]);
        end
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0; in_new_cw = 0;
        exp_count = nc ? 1 : (exp_count < MX ? exp_count + 1 : MX);
        chk({req, " R5 done"}, int'(done_o), 1);
        chk({req, " converged"}, int'(converged_o), int'(exp_conv));
        chk({req, " R7 stop"}, int'(stop_o), int'(exp_conv || exp_count == MX));
        chk({req, " R6 count"}, int'(iter_count_o), exp_count);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R8 done", int'(done_o), 0);
        chk("R8 stop", int'(stop_o), 0);
        chk("R8 conv", int'(converged_o), 0);
        chk("R8 count", int'(iter_count_o), 0);
    endtask

    task automatic t_basic();
        make_clean(8, 16'hB2);
        send_frame(8, 1, 0, 1, "R2 clean");
        make_clean(8, 16'hB2); f1[3] = -f1[3];
        send_frame(8, 0, 0, 0, "R4 mismatch");
        make_clean(8, 16'hB2);
        send_frame(8, 0, 0, 1, "R4 cleared");
        @(negedge clk);
        chk("R8 hold conv", int'(converged_o), 1);
        chk("R8 hold count", int'(iter_count_o), 3);
    endtask

    task automatic t_tailbite();
        make_clean(8, 16'hB2);          // u0=0, u7=1: position 0 codes to 1
        send_frame(8, 1, 0, 1, "R3 wrap good");
        make_clean(8, 16'hB2); f0[0] = -5; f1[0] = -5;
        send_frame(8, 0, 0, 0, "R3 zero-start rejected");
    endtask

    task automatic t_zero();
        make_clean(8, 16'hB2); fi[3] = 0; f0[5] = 0;
        send_frame(8, 1, 0, 1, "R1 zero to 0");
        make_clean(8, 16'hB2); f0[1] = 0;
        send_frame(8, 0, 0, 0, "R1 zero vs 1");
        make_clean(8, 16'hB2); fi[4] = 0;
        send_frame(8, 0, 0, 0, "R1 info zero");
    endtask

    task automatic t_gaps();
        make_clean(6, 16'h2D);
        send_frame(6, 1, 1, 1, "R5 gaps");
    endtask

    task automatic t_limit();
        for (int k = 0; k < 33; k++) begin
            make_clean(8, 16'h5A); f0[6] = -f0[6];
            send_frame(8, k == 0, 0, 0, "R7 limit");
        end
        make_clean(8, 16'h5A);
        send_frame(8, 1, 0, 1, "R6 new cw restart");
    endtask

    task automatic t_single();
        fi[0] = 5; f0[0] = -5; f1[0] = -5;
        send_frame(1, 1, 0, 1, "R9 one beat");
        fi[0] = -5; f0[0] = -5; f1[0] = 5;
        send_frame(1, 0, 0, 0, "R9 one beat bad");
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_basic();
        t_tailbite();
        t_zero();
        t_gaps();
        t_limit();
        t_single();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule